// File: doc/BRIEF.md
# Programmable IDE PIO Strobe Timer

This block times the read and write strobes of a two-channel IDE host interface, counting in cycles of the local bus clock. A host writes two 8-bit timer registers and one control register through a small write/read register port. Each timer register holds two fields, stored as complemented cycle counts. The low nibble sets how long the strobe stays asserted. The high nibble sets how long the bus then stays idle for recovery.

Accesses arrive on a valid/ready port that carries a 2-bit drive number and a direction bit. Back-pressure is simple. `acc_ready` is high only while the timer is idle, and an access is taken on the rising edge where `acc_valid` and `acc_ready` are both high. The requester must hold `acc_valid` and its fields steady until that edge. After the handshake, `acc_ready` stays low through the strobe and recovery phases. `acc_done` pulses in the last recovery cycle, and `acc_ready` returns high on the next cycle.

Control bit 0 selects how drives map to timers. With the bit set, each primary drive gets its own timer. With the bit clear, each channel shares one timer between its two drives.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, both timer registers and the control register read 0x00, `ior_n` and `iow_n` are high, `acc_ready` is high, and `acc_done` is low.
- R2: The strobe stays low for 17 − L cycles, where L is bits [3:0] of the selected timer register.
- R3: Recovery lasts 15 − H cycles, where H is bits [7:4] of the selected timer register. H = 14 and H = 15 both give 2 cycles. Recovery is counted from the first cycle after the strobe rises, up to and including the `acc_done` cycle.
- R4: Register address 0 holds timer A, address 2 holds timer B, and address 3 holds the control register. Address 1 reads 0x00, and a write to it changes nothing.
- R5: Control bits 0–3, 6 and 7 read back as written. Control bits 4 and 5 read 0.
- R6: When control bit 0 is 1, a drive number with bit 0 = 0 uses timer A, and one with bit 0 = 1 uses timer B.
- R7: When control bit 0 is 0, drive numbers 0 and 1 (bit 1 = 0) use timer A, and drive numbers 2 and 3 use timer B.
- R8: `acc_ready` is low from the cycle after a handshake through the `acc_done` cycle. A request held valid during that time is not taken.
- R9: `acc_done` is high for exactly one cycle, the last recovery cycle. `acc_ready` is high in the following cycle.
- R10: When `acc_rd` = 1 the access pulses `ior_n`, and when it is 0 it pulses `iow_n`. The other strobe stays high.
- R11: The timer value is captured at the handshake. A register write during an access affects only later accesses.
- R12: The strobe goes low in the cycle right after the handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Timer idle, request can be taken |
| acc_drive | input | 2 | Drive number of the request |
| acc_rd | input | 1 | 1 = read strobe, 0 = write strobe |
| ior_n | output | 1 | Read strobe, active low |
| iow_n | output | 1 | Write strobe, active low |
| acc_done | output | 1 | One-cycle pulse at the end of recovery |

## Verification
Some rules are checked by assertions on every cycle:
- a strobe is never low while `acc_ready` is high;
- a handshake is followed by a strobe;
- `acc_done` is followed by ready;
- the latched timer value stays steady while busy;
- the counter stays within range;
- register writes land.

Other behaviour can only be shown by the bench's scenarios. These are the exact strobe and recovery lengths for all 256 timer values (including the recovery clamp), the drive-to-timer mapping in both modes, the read-back masks, and the effect of a write made mid-access.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2
  } pio_state_e;
endpackage

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int OFS_TA   = 0,
  parameter int OFS_TB   = 2,
  parameter int OFS_CTL  = 3,
  parameter logic [7:0] CTL_MASK = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] timer_a,
  output logic [DATA_W-1:0] timer_b,
  output logic [DATA_W-1:0] ctl
);
  localparam logic [ADDR_W-1:0] A_TA  = ADDR_W'(OFS_TA);
  localparam logic [ADDR_W-1:0] A_TB  = ADDR_W'(OFS_TB);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [DATA_W-1:0] MASK  = DATA_W'(CTL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_a <= '0;
      timer_b <= '0;
      ctl     <= '0;
    end else if (we) begin
      if (addr == A_TA)  timer_a <= wdata;
      if (addr == A_TB)  timer_b <= wdata;
      if (addr == A_CTL) ctl     <= wdata & MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_TA)  rdata = timer_a;
    if (addr == A_TB)  rdata = timer_b;
    if (addr == A_CTL) rdata = ctl;
  end

  // R4
  ta_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_TA) |=> (timer_a == $past(wdata)));

  // R5
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl & ~MASK) == '0);
endmodule

// File: rtl/pio_timer_sel.sv
module pio_timer_sel #(
  parameter int DATA_W = 8
) (
  input  logic              solo_mode,
  input  logic [1:0]        drive,
  input  logic [DATA_W-1:0] timer_a,
  input  logic [DATA_W-1:0] timer_b,
  output logic [DATA_W-1:0] timer
);
  logic use_b;

  always_comb begin
    use_b = solo_mode ? drive[0] : drive[1];
    timer = use_b ? timer_b : timer_a;
  end
endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
  import pio_tmr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ACT_BASE = 17,
  parameter int REC_BASE = 15,
  parameter int REC_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  output logic              ready,
  input  logic [DATA_W-1:0] timer_in,
  input  logic              rd_in,
  output logic              ior_n,
  output logic              iow_n,
  output logic              done
);
  localparam int NIB_W = DATA_W / 2;
  localparam int CNT_W = $clog2(ACT_BASE + 1);
  localparam int REC_CLAMP_AT = REC_BASE - REC_MIN;

  pio_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lat_timer;
  logic              lat_rd;
  logic [CNT_W-1:0]  act_m1;
  logic [CNT_W-1:0]  rec_m1;
  logic [NIB_W-1:0]  lo_nib;
  logic [NIB_W-1:0]  hi_nib;

  always_comb begin
    lo_nib = timer_in[NIB_W-1:0];
    hi_nib = lat_timer[DATA_W-1:NIB_W];
    act_m1 = CNT_W'(ACT_BASE - 1) - CNT_W'(lo_nib);
    if (32'(hi_nib) > REC_CLAMP_AT)
      rec_m1 = CNT_W'(REC_MIN - 1);
    else
      rec_m1 = CNT_W'(REC_BASE - 1) - CNT_W'(hi_nib);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lat_timer <= '0;
      lat_rd    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (valid) begin
          state     <= ST_ACT;
          cnt       <= act_m1;
          lat_timer <= timer_in;
          lat_rd    <= rd_in;
        end
        ST_ACT: if (cnt == '0) begin
          state <= ST_REC;
          cnt   <= rec_m1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_REC: if (cnt == '0) begin
          state <= ST_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready = (state == ST_IDLE);
    done  = (state == ST_REC) && (cnt == '0);
    ior_n = !((state == ST_ACT) && lat_rd);
    iow_n = !((state == ST_ACT) && !lat_rd);
  end

  // R8
  no_strobe_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n || !iow_n) |-> !ready);

  // R12
  strobe_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> (!ior_n || !iow_n));

  // R9
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready && !done));

  // R11
  timer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |-> $stable(lat_timer));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < ACT_BASE);
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int ACT_BASE = 17,
  parameter int REC_BASE = 15,
  parameter int REC_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [1:0]        acc_drive,
  input  logic              acc_rd,
  output logic              ior_n,
  output logic              iow_n,
  output logic              acc_done
);
  logic [DATA_W-1:0] timer_a;
  logic [DATA_W-1:0] timer_b;
  logic [DATA_W-1:0] ctl;
  logic [DATA_W-1:0] sel_timer;

  pio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .timer_a(timer_a), .timer_b(timer_b), .ctl(ctl)
  );

  pio_timer_sel #(.DATA_W(DATA_W)) u_sel (
    .solo_mode(ctl[0]), .drive(acc_drive),
    .timer_a(timer_a), .timer_b(timer_b), .timer(sel_timer)
  );

  pio_strobe_fsm #(
    .DATA_W(DATA_W), .ACT_BASE(ACT_BASE),
    .REC_BASE(REC_BASE), .REC_MIN(REC_MIN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .valid(acc_valid), .ready(acc_ready),
    .timer_in(sel_timer), .rd_in(acc_rd),
    .ior_n(ior_n), .iow_n(iow_n), .done(acc_done)
  );
endmodule

// File: tb/pio_strobe_timer_bench.sv
module pio_strobe_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic [1:0] acc_drive = '0;
  logic       acc_rd = 1'b0;
  logic       ior_n, iow_n, acc_done;
  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  pio_strobe_timer u_pio_strobe_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_drive(acc_drive),
    .acc_rd(acc_rd), .ior_n(ior_n), .iow_n(iow_n), .acc_done(acc_done)
  );

  function automatic int exp_act(input logic [7:0] t);
    return 17 - int'(t[3:0]);
  endfunction

  function automatic int exp_rec(input logic [7:0] t);
    int h = int'(t[7:4]);
    return (h >= 14) ? 2 : 15 - h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // Runs one access; counts strobe cycles and recovery cycles.
  task automatic access(input logic [1:0] drv, input bit rd, input bit poke,
                        input logic [7:0] pdata, output int act, output int rec,
                        output int bad);
    act = 0; rec = 0; bad = 0;
    @(negedge clk);
    if (!acc_ready) bad++;
    acc_valid = 1'b1; acc_drive = drv; acc_rd = rd;
    @(negedge clk);
    acc_valid = 1'b0;
    if (rd ? ior_n : iow_n) bad++;              // R12 first cycle low
    for (int i = 0; i < 100; i++) begin
      if (poke && i == 0) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = pdata;
      end
      if (poke && i == 1) cfg_we = 1'b0;
      if (acc_ready) bad++;                      // R8
      if (rd ? !iow_n : !ior_n) bad++;           // R10
      if (!(rd ? ior_n : iow_n)) begin
        if (rec > 0) bad++;
        act++;
      end else begin
        rec++;
        if (acc_done) break;
      end
      if (i == 99) bad += 100;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    @(negedge clk);
    if (!acc_ready || acc_done) bad++;           // R9
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] rv;
    int a, r, b;
    logic [7:0] ta, tb;
    logic [7:0] tsel;
    int hits;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ior_n && iow_n && acc_ready && !acc_done, "R1 idle outputs", {ior_n, iow_n, acc_ready, acc_done}, 4'b1110);
    for (int k = 0; k < 4; k++) begin
      cfg_read(2'(k), rv);
      chk(rv == 8'h00, "R1 reset register", rv, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R4 address map and ignored address 1
    cfg_write(2'd0, 8'h5A);
    cfg_write(2'd2, 8'hC3);
    cfg_write(2'd1, 8'hFF);
    cfg_read(2'd0, rv); chk(rv == 8'h5A, "R4 timer A", rv, 8'h5A);
    cfg_read(2'd2, rv); chk(rv == 8'hC3, "R4 timer B", rv, 8'hC3);
    cfg_read(2'd1, rv); chk(rv == 8'h00, "R4 address 1", rv, 0);
    cfg_read(2'd3, rv); chk(rv == 8'h00, "R4 control untouched", rv, 0);

    // R5 control mask
    cfg_write(2'd3, 8'hFF);
    cfg_read(2'd3, rv); chk(rv == 8'hCF, "R5 control all ones", rv, 8'hCF);
    cfg_write(2'd3, 8'h30);
    cfg_read(2'd3, rv); chk(rv == 8'h00, "R5 control bits 4-5", rv, 0);
    cfg_write(2'd3, 8'h00);

    // Reset timing 0x00: slowest
    cfg_write(2'd0, 8'h00);
    access(2'd0, 1'b1, 1'b0, 8'h00, a, r, b);
    chk(a == 17, "R2 reset-value active", a, 17);
    chk(r == 15 && b == 0, "R3 reset-value recovery", r, 15);

    // R2 R3 R10 sweep of all timer values, shared mode drive 0
    for (int v = 0; v < 256; v++) begin
      cfg_write(2'd0, 8'(v));
      access(2'd0, v[0], 1'b0, 8'h00, a, r, b);
      chk(a == exp_act(8'(v)), "R2 active length", a, exp_act(8'(v)));
      chk(r == exp_rec(8'(v)), "R3 recovery length", r, exp_rec(8'(v)));
      chk(b == 0, "R8 R9 R10 R12 handshake and strobe rules", b, 0);
    end

    // R6 R7 drive mapping
    ta = 8'h25; tb = 8'hA9;
    cfg_write(2'd0, ta);
    cfg_write(2'd2, tb);
    for (int m = 0; m < 2; m++) begin
      cfg_write(2'd3, 8'(m));
      for (int d = 0; d < 4; d++) begin
        if (m == 1) tsel = d[0] ? tb : ta;
        else        tsel = d[1] ? tb : ta;
        access(2'(d), d[0], 1'b0, 8'h00, a, r, b);
        chk(a == exp_act(tsel) && r == exp_rec(tsel) && b == 0,
            (m == 1) ? "R6 solo mapping" : "R7 shared mapping", a * 100 + r,
            exp_act(tsel) * 100 + exp_rec(tsel));
      end
    end
    cfg_write(2'd3, 8'h00);

    // R11 write during access
    cfg_write(2'd0, 8'h0F);
    access(2'd0, 1'b0, 1'b1, 8'h00, a, r, b);
    chk(a == 2 && r == 15, "R11 latched during access", a * 100 + r, 215);
    access(2'd0, 1'b0, 1'b0, 8'h00, a, r, b);
    chk(a == 17 && r == 15, "R11 new value next access", a * 100 + r, 1715);

    // R8 request held valid during busy is not taken early
    cfg_write(2'd0, 8'hEF);           // act 2, rec 2
    @(negedge clk);
    acc_valid = 1'b1; acc_drive = 2'd0; acc_rd = 1'b1;
    hits = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!ior_n) hits++;
    end
    acc_valid = 1'b0;
    // cycles: 2 strobe, 2 rec, 1 idle per access -> 12 cycles hold 2+2+1+2+2+1+2 = strobe 6
    chk(hits == 6, "R8 back-to-back spacing", hits, 6);
    repeat (8) @(negedge clk);
    report();
  end
endmodule